// File: doc/BRIEF.md
# Configurable PLA Logic Array

This block is a sum-of-products logic array whose AND plane and OR plane are both set by configuration bits. Each of the `N_TERM` product terms ANDs any chosen mix of the `N_IN` inputs and their complements. Each of the `N_OUT` outputs ORs any chosen mix of the product terms. Because the OR plane is programmable, one product term can feed several outputs. The path from `in_vec` to `out_vec` is purely combinational.

The connection bits are loaded one bit per clock through a serial chain, least significant bit first, while `cfg_en` is high. The chain is a shadow store, so the array keeps its old function during a load. The new pattern is copied into the live store on the clock edge that sees `cfg_en` low after a high. `cfg_out` always shows bit 0 of the chain. If `cfg_out` is fed back into `cfg_in` for one full pass, the chain can be read without losing its contents.

Top module: `pla_array`

## Requirements
- R1: A product term is the AND of the literals it is connected to. For term t and input i, configuration bit t*2*N_IN + 2*i connects the true input and bit t*2*N_IN + 2*i + 1 connects its complement.
- R2: A product term with no connected literals evaluates to 1.
- R3: A product term connected to both an input and that input's complement evaluates to 0.
- R4: Output o is the OR of the terms connected to it. Bit 2*N_IN*N_TERM + o*N_TERM + t connects term t to output o, and one term may drive several outputs.
- R5: An output with no connected terms drives 0.
- R6: While `cfg_en` is high, each clock shifts the chain one place toward bit 0 and enters `cfg_in` at the top bit. After 2*N_IN*N_TERM + N_OUT*N_TERM shifts, the first bit entered sits at index 0.
- R7: The live configuration does not change while `cfg_en` is high. It takes the chain contents on the first clock edge where `cfg_en` is low after being high.
- R8: `cfg_out` shows chain bit 0, so consecutive shifts present the loaded bits in index order. A full pass with `cfg_in` driven from `cfg_out` leaves the chain unchanged.
- R9: After reset, the chain and the live configuration are all zero, so every output is 0 and `cfg_out` is 0.
- R10: While `cfg_en` is low, `cfg_in` is ignored and the chain holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | High to shift the chain; its falling edge commits the load |
| cfg_in | input | 1 | Serial configuration data, least significant bit first |
| cfg_out | output | 1 | Chain bit 0, used for readback |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Sum-of-products results |

## Verification
The assertions take for granted that `cfg_en` and `cfg_in` change only away from the rising clock edge, and that `cfg_en` stays low while the internal reset is active. The bench keeps to this: it changes every input on the falling edge, holds `cfg_en` low through reset, and waits for the synchronizer to release before it starts a load. The logic inputs are never X after reset. Every output comparison is made half a cycle away from any edge that could move the live store.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Position of a literal connection in the AND plane.
  function automatic int unsigned lit_pos(int unsigned term, int unsigned inp,
                                          int unsigned neg, int unsigned n_in);
    return term * 2 * n_in + 2 * inp + neg;
  endfunction

  // Position of a term-to-output connection, counted from the start of the OR plane.
  function automatic int unsigned sum_pos(int unsigned outp, int unsigned term,
                                          int unsigned n_term);
    return outp * n_term + term;
  endfunction
endpackage

// File: rtl/pla_rst_sync.sv
module pla_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pla_shift_chain.sv
module pla_shift_chain #(
  parameter int unsigned WIDTH = 66
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] chain_o
);
  logic [WIDTH-1:0] chain_d, chain_q;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {ser_in, chain_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (shift_en) chain_q <= chain_d;
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 6
) (
  input  logic [N_IN-1:0]          in_vec,
  input  logic [N_TERM*2*N_IN-1:0] and_cfg,
  output logic [N_TERM-1:0]        term_o
);
  localparam int unsigned LITS = 2 * N_IN;

  logic [LITS-1:0] lits;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = in_vec[i];
    assign lits[2*i+1] = ~in_vec[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LITS-1:0] mask;
    assign mask      = and_cfg[t*LITS +: LITS];
    // A disconnected literal is forced to 1 so it cannot pull the AND low.
    assign term_o[t] = &(lits | ~mask);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_TERM = 6,
  parameter int unsigned N_OUT  = 3
) (
  input  logic [N_TERM-1:0]       term_i,
  input  logic [N_OUT*N_TERM-1:0] or_cfg,
  output logic [N_OUT-1:0]        out_vec
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    assign out_vec[o] = |(term_i & or_cfg[o*N_TERM +: N_TERM]);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_OUT  = 3,
  parameter int unsigned N_TERM = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_in,
  output logic              cfg_out,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  out_vec
);
  localparam int unsigned AND_BITS = N_TERM * 2 * N_IN;
  localparam int unsigned OR_BITS  = N_OUT * N_TERM;
  localparam int unsigned CFG_BITS = AND_BITS + OR_BITS;

  logic                rst_ni;
  logic [CFG_BITS-1:0] cfg_shadow;
  logic [CFG_BITS-1:0] cfg_act_d, cfg_act_q;
  logic                en_d, en_q;
  logic                commit;
  logic [N_TERM-1:0]   terms;

  pla_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  pla_shift_chain #(.WIDTH(CFG_BITS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_ni),
    .shift_en (cfg_en),
    .ser_in   (cfg_in),
    .chain_o  (cfg_shadow)
  );

  // Commit on the first edge that sees cfg_en low after it was high.
  always_comb begin
    en_d      = cfg_en;
    commit    = en_q & ~cfg_en;
    cfg_act_d = commit ? cfg_shadow : cfg_act_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      cfg_act_q <= '0;
    end else begin
      en_q <= en_d;
      if (commit) cfg_act_q <= cfg_act_d;
    end
  end

  assign cfg_out = cfg_shadow[0];

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_vec  (in_vec),
    .and_cfg (cfg_act_q[AND_BITS-1:0]),
    .term_o  (terms)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term_i  (terms),
    .or_cfg  (cfg_act_q[CFG_BITS-1:AND_BITS]),
    .out_vec (out_vec)
  );
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int unsigned CFG_BITS = 66,
  parameter int unsigned N_OUT    = 3
) (
  input logic                clk,
  input logic                rst_ni,
  input logic                cfg_en,
  input logic                cfg_in,
  input logic                cfg_out,
  input logic [CFG_BITS-1:0] cfg_shadow,
  input logic [CFG_BITS-1:0] cfg_act_q,
  input logic [N_OUT-1:0]    out_vec
);
  // R7: the live store holds while loading
  a_r7_hold_during_load: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_en |=> $stable(cfg_act_q));

  // R7: the live store takes the chain after cfg_en falls
  a_r7_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(cfg_en) && !cfg_en) |=> (cfg_act_q == $past(cfg_shadow)));

  // R6: the serial bit enters at the top of the chain
  a_r6_shift_entry: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_en |=> (cfg_shadow[CFG_BITS-1] == $past(cfg_in)));

  // R8: the next bit read out is the one that was just above bit 0
  a_r8_readout_advance: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_en |=> (cfg_out == $past(cfg_shadow[1])));

  // R10: the chain holds while cfg_en is low
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !cfg_en |=> $stable(cfg_shadow));

  // R5: an empty configuration drives every output low
  a_r5_empty_low: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_act_q == '0) |-> (out_vec == '0));
endmodule

bind pla_array pla_array_chk #(.CFG_BITS(CFG_BITS), .N_OUT(N_OUT)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_ni),
  .cfg_en     (cfg_en),
  .cfg_in     (cfg_in),
  .cfg_out    (cfg_out),
  .cfg_shadow (cfg_shadow),
  .cfg_act_q  (cfg_act_q),
  .out_vec    (out_vec)
);

// File: tb/pla_array_tb_top.sv
module pla_array_tb_top;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int NT = 6;
  localparam int AB = NT * 2 * NI;
  localparam int CB = AB + NO * NT;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_en;
  logic          cfg_in;
  logic          cfg_out;
  logic [NI-1:0] in_vec;
  logic [NO-1:0] out_vec;

  int n_chk  = 0;
  int n_fail = 0;
  logic [CB-1:0] cur_cfg;
  logic [CB-1:0] cfg_a, cfg_b, cfg_c;

  always #2 clk = ~clk;

  pla_array #(.N_IN(NI), .N_OUT(NO), .N_TERM(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .in_vec(in_vec), .out_vec(out_vec)
  );

  function automatic int lbit(int t, int i, int neg);
    return t * 2 * NI + 2 * i + neg;
  endfunction

  function automatic int obit(int o, int t);
    return AB + o * NT + t;
  endfunction

  function automatic logic [NO-1:0] model(logic [CB-1:0] c, logic [NI-1:0] x);
    logic [NO-1:0] r = '0;
    logic [NT-1:0] tv;
    for (int t = 0; t < NT; t++) begin
      tv[t] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (c[lbit(t, i, 0)] && !x[i]) tv[t] = 1'b0;
        if (c[lbit(t, i, 1)] &&  x[i]) tv[t] = 1'b0;
      end
    end
    for (int o = 0; o < NO; o++)
      for (int t = 0; t < NT; t++)
        if (c[obit(o, t)] && tv[t]) r[o] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // R1 R4: compare every input pattern against the model
  task automatic sweep(string req, logic [CB-1:0] c);
    for (int x = 0; x < (1 << NI); x++) begin
      @(negedge clk);
      in_vec = NI'(x);
      #1;
      check(req, 32'(out_vec), 32'(model(c, NI'(x))));
    end
  endtask

  // R7: load a pattern and confirm the old function holds until the commit
  task automatic load_cfg(logic [CB-1:0] v);
    for (int k = 0; k < CB; k++) begin
      @(negedge clk);
      if (k == CB / 2) check("R7 hold mid-load", 32'(out_vec), 32'(model(cur_cfg, in_vec)));
      cfg_en = 1'b1;
      cfg_in = v[k];
    end
    @(negedge clk);
    check("R7 hold before commit", 32'(out_vec), 32'(model(cur_cfg, in_vec)));
    cfg_en = 1'b0;
    cfg_in = 1'b0;
    @(negedge clk);
    cur_cfg = v;
  endtask

  // R6 R8: recirculating readback of the whole chain
  task automatic readback(string req, logic [CB-1:0] v);
    for (int k = 0; k < CB; k++) begin
      @(negedge clk);
      check(req, 32'(cfg_out), 32'(v[k]));
      cfg_en = 1'b1;
      cfg_in = cfg_out;
    end
    @(negedge clk);
    cfg_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_en = 1'b0; cfg_in = 1'b0; in_vec = '0;
    cur_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 cfg_out after reset", 32'(cfg_out), 32'd0);
    for (int x = 0; x < (1 << NI); x += 5) begin
      in_vec = NI'(x);
      #1;
      check("R9 R5 outputs after reset", 32'(out_vec), 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_shared_terms();
    cfg_a = '0;
    cfg_a[lbit(0, 0, 0)] = 1'b1; cfg_a[lbit(0, 1, 0)] = 1'b1;
    cfg_a[lbit(1, 2, 1)] = 1'b1;
    cfg_a[lbit(2, 3, 0)] = 1'b1; cfg_a[lbit(2, 0, 1)] = 1'b1;
    cfg_a[lbit(5, 2, 0)] = 1'b1; cfg_a[lbit(5, 3, 0)] = 1'b1;
    cfg_a[obit(0, 0)] = 1'b1; cfg_a[obit(0, 1)] = 1'b1;
    cfg_a[obit(1, 1)] = 1'b1; cfg_a[obit(1, 2)] = 1'b1; cfg_a[obit(1, 5)] = 1'b1;
    load_cfg(cfg_a);
    sweep("R1 R4 shared terms", cfg_a);
    for (int x = 0; x < (1 << NI); x += 3) begin
      @(negedge clk); in_vec = NI'(x); #1;
      check("R5 unconnected output", 32'(out_vec[2]), 32'd0);
    end
  endtask

  task automatic t_degenerate_terms();
    cfg_b = '0;
    cfg_b[lbit(4, 1, 0)] = 1'b1; cfg_b[lbit(4, 1, 1)] = 1'b1;
    cfg_b[obit(0, 3)] = 1'b1;
    cfg_b[obit(1, 4)] = 1'b1;
    cfg_b[obit(2, 3)] = 1'b1; cfg_b[obit(2, 4)] = 1'b1;
    load_cfg(cfg_b);
    for (int x = 0; x < (1 << NI); x++) begin
      @(negedge clk); in_vec = NI'(x); #1;
      check("R2 empty term is one", 32'(out_vec[0]), 32'd1);
      check("R3 x and not x is zero", 32'(out_vec[1]), 32'd0);
      check("R4 OR of one and zero", 32'(out_vec[2]), 32'd1);
    end
  endtask

  task automatic t_bit_order();
    cfg_c = '0;
    cfg_c[lbit(0, 2, 0)] = 1'b1;
    cfg_c[lbit(3, 2, 1)] = 1'b1;
    cfg_c[obit(0, 0)] = 1'b1;
    cfg_c[obit(2, 3)] = 1'b1;
    load_cfg(cfg_c);
    for (int x = 0; x < (1 << NI); x++) begin
      @(negedge clk); in_vec = NI'(x); #1;
      check("R6 first bits land in term 0", 32'(out_vec), 32'({~x[2], 1'b0, x[2]}));
    end
  endtask

  task automatic t_readback();
    load_cfg(cfg_a);
    readback("R6 R8 readback order", cfg_a);
    sweep("R8 function kept after recirculation", cfg_a);
  endtask

  task automatic t_idle_ignore();
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      cfg_in = k[0] ^ k[2];
    end
    sweep("R10 R7 outputs unchanged when idle", cfg_a);
    readback("R10 chain unchanged when idle", cfg_a);
  endtask

  initial begin
    t_reset();
    t_shared_terms();
    t_degenerate_terms();
    t_bit_order();
    t_readback();
    t_idle_ignore();
    finish_run();
  end
endmodule